// File: doc/BRIEF.md
# Glitch-Free Multi-Bank Clock Divider

This block takes one fast source clock and derives three banks of four divided clocks, plus one feedback clock, from it. Each bank has a 2-bit ratio select, and the feedback clock has a 3-bit select. A global full-rate input chooses between the selected ratios and ratios that are twice as long. All counting and all outputs sit in the source clock domain, so the outputs of one bank move on the same source edge.

Ratio selects may change while the clock runs. A new ratio is held back until the running output period completes. An output period therefore always belongs wholly to the old ratio or wholly to the new one, which rules out both runt and stretched cycles.

Each bank output has an enable bit. A disabled output parks at logic 0. Enable changes are synchronised and then applied only while the affected output is low. In the last bank, the upper two outputs can be driven inverted.

Top module: `clkdiv_banks`

## Requirements
- R1: With `vco_full_i`=1, bank A (`qa_o`) toggles with a period of 4, 6, 8 or 12 source cycles for `sel_a_i` = 0, 1, 2 or 3. Every period is high for the first half and low for the second half.
- R2: With `vco_full_i`=1, bank B (`qb_o`) has a period of 4, 6, 8 or 10 source cycles for `sel_b_i` = 0, 1, 2 or 3, with a 50% duty cycle.
- R3: With `vco_full_i`=1, bank C (`qc_o`) has a period of 2, 4, 6 or 8 source cycles for `sel_c_i` = 0, 1, 2 or 3, with a 50% duty cycle.
- R4: `fb_o` has a period of 4, 6, 8 or 10 source cycles for `fb_sel_i[1:0]` = 0, 1, 2 or 3 when `fb_sel_i[2]`=0, and twice those values when `fb_sel_i[2]`=1. It has a 50% duty cycle and no enable.
- R5: With `vco_full_i`=0, every bank period and the feedback period are doubled.
- R6: A change of any select or of `vco_full_i` is adopted only at the end of a full output period. Every high run and every low run of an output equals half of either the old period or the new period.
- R7: With `inv_c_i`=1, `qc_o[2]` and `qc_o[3]` are the complement of the bank C clock. With `inv_c_i`=0, they equal it. `inv_c_i` is meant to change only while reset is held.
- R8: `out_en_i` bits 3:0 enable `qa_o[3:0]`, bits 7:4 enable `qb_o[3:0]`, and bits 11:8 enable `qc_o[3:0]`. An output whose bit is 0 stays at logic 0.
- R9: Enabling or disabling an output never produces a partial high pulse. Every high pulse lasts exactly half a period.
- R10: While `rst_ni` is low, every output is 0. After release, each divided clock starts with a full high half-period.
- R11: Outputs of one bank that are enabled and not inverted change on the same source edge, each rising at the start of a bank period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_a_i | input | 2 | Bank A ratio select |
| sel_b_i | input | 2 | Bank B ratio select |
| sel_c_i | input | 2 | Bank C ratio select |
| fb_sel_i | input | 3 | Feedback ratio select, bit 2 doubles |
| vco_full_i | input | 1 | 1: selected ratios, 0: ratios doubled |
| inv_c_i | input | 1 | Invert the upper two bank C outputs |
| out_en_i | input | 12 | Per-output enable, bank A in the low nibble |
| qa_o | output | 4 | Bank A clocks |
| qb_o | output | 4 | Bank B clocks |
| qc_o | output | 4 | Bank C clocks |
| fb_o | output | 1 | Feedback clock |

## Verification
The bench builds the block with its default parameters: four outputs per bank, a two-stage enable synchroniser and a 6-bit period counter. With these values the longest period is 40 source cycles, which keeps a complete sweep cheap. The sweep covers every select code of every bank and of the feedback path in both full-rate and doubled mode, changing the selects on the fly. A run-length monitor checks each high and low run against the old and new half-periods across every change. Enable toggling at many phases and inverted bank C outputs are also reachable within a short run.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int RATIO_W = 6;

  typedef enum logic [1:0] {BANK_A, BANK_B, BANK_C, BANK_FB} bank_e;

  // period in source cycles; full=0 doubles it
  function automatic logic [RATIO_W-1:0] bank_ratio(bank_e b, logic [2:0] sel, logic full);
    logic [RATIO_W-1:0] base;
    logic [RATIO_W-1:0] step;
    step = RATIO_W'({sel[1:0], 1'b0});
    case (b)
      BANK_A:  base = (sel[1:0] == 2'd3) ? RATIO_W'(12) : RATIO_W'(4) + step;
      BANK_B:  base = RATIO_W'(4) + step;
      BANK_C:  base = RATIO_W'(2) + step;
      default: base = sel[2] ? (RATIO_W'(4) + step) << 1 : RATIO_W'(4) + step;
    endcase
    return full ? base : base << 1;
  endfunction
endpackage

// File: rtl/clkdiv_sync.sv
module clkdiv_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ratio_i,
  output logic         level_d_o,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] ratio_o
);
  logic [W-1:0] cnt_q, cnt_d, ratio_q, ratio_d;
  logic         wrap;

  // ratio_q==0 only after reset: first edge starts a fresh period
  assign wrap    = (ratio_q == '0) || (cnt_q == ratio_q - W'(1));
  assign cnt_d   = wrap ? '0 : cnt_q + W'(1);
  assign ratio_d = wrap ? ratio_i : ratio_q;
  assign level_d_o = cnt_d < (ratio_d >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign ratio_o = ratio_q;
endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_d_i,
  input  logic inv_i,
  input  logic en_i,
  output logic q_o
);
  logic val_d, gate_q, q_q;

  assign val_d = level_d_i ^ inv_i;

  // enable is taken over only on edges that leave the output low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      q_q    <= 1'b0;
    end else begin
      if (!val_d) gate_q <= en_i;
      q_q <= val_d & gate_q;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/clkdiv_banks.sv
module clkdiv_banks
  import clkdiv_pkg::*;
#(
  parameter int BANK_OUTS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             sel_a_i,
  input  logic [1:0]             sel_b_i,
  input  logic [1:0]             sel_c_i,
  input  logic [2:0]             fb_sel_i,
  input  logic                   vco_full_i,
  input  logic                   inv_c_i,
  input  logic [3*BANK_OUTS-1:0] out_en_i,
  output logic [BANK_OUTS-1:0]   qa_o,
  output logic [BANK_OUTS-1:0]   qb_o,
  output logic [BANK_OUTS-1:0]   qc_o,
  output logic                   fb_o
);
  localparam int NUM_BANKS = 3;
  localparam int NUM_DIV   = NUM_BANKS + 1;
  localparam int EN_W      = NUM_BANKS * BANK_OUTS;

  logic [NUM_DIV-1:0][2:0]         sel_w;
  logic [NUM_DIV-1:0][RATIO_W-1:0] cnt_w, ratio_w;
  logic [NUM_DIV-1:0]              lvl_d;
  logic [EN_W-1:0]                 en_s;
  logic [NUM_BANKS-1:0][BANK_OUTS-1:0] bank_q;
  logic                            fb_q;

  assign sel_w[0] = {1'b0, sel_a_i};
  assign sel_w[1] = {1'b0, sel_b_i};
  assign sel_w[2] = {1'b0, sel_c_i};
  assign sel_w[3] = fb_sel_i;

  clkdiv_sync #(.W(EN_W), .STAGES(SYNC_STAGES)) u_en_sync (
    .clk_i, .rst_ni, .d_i(out_en_i), .q_o(en_s)
  );

  for (genvar k = 0; k < NUM_DIV; k++) begin : g_div
    clkdiv_counter #(.W(RATIO_W)) u_cnt (
      .clk_i,
      .rst_ni,
      .ratio_i  (bank_ratio(bank_e'(k), sel_w[k], vco_full_i)),
      .level_d_o(lvl_d[k]),
      .cnt_o    (cnt_w[k]),
      .ratio_o  (ratio_w[k])
    );
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar o = 0; o < BANK_OUTS; o++) begin : g_out
      localparam bit INV_OK = (b == NUM_BANKS - 1) && (o >= BANK_OUTS / 2);
      clkdiv_gate u_gate (
        .clk_i,
        .rst_ni,
        .level_d_i(lvl_d[b]),
        .inv_i    (INV_OK ? inv_c_i : 1'b0),
        .en_i     (en_s[b*BANK_OUTS+o]),
        .q_o      (bank_q[b][o])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fb_q <= 1'b0;
    else         fb_q <= lvl_d[NUM_DIV-1];
  end

  assign qa_o = bank_q[0];
  assign qb_o = bank_q[1];
  assign qc_o = bank_q[2];
  assign fb_o = fb_q;
endmodule

// File: rtl/clkdiv_banks_chk.sv
module clkdiv_banks_chk #(
  parameter int W         = 6,
  parameter int BANK_OUTS = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   inv_c_i,
  input logic [BANK_OUTS-1:0]   qa_o,
  input logic [BANK_OUTS-1:0]   qb_o,
  input logic [BANK_OUTS-1:0]   qc_o,
  input logic                   fb_o,
  input logic [3:0][W-1:0]      cnt_i,
  input logic [3:0][W-1:0]      ratio_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R10: assert (qa_o == '0 && qb_o == '0 && qc_o == '0 && !fb_o)
        else $error("outputs active in reset");
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_ratio
    assert_ratio_at_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(ratio_i[k]) |-> cnt_i[k] == '0);
  end

  for (genvar o = 0; o < BANK_OUTS; o++) begin : g_ab
    assert_qa_rise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(qa_o[o]) |-> cnt_i[0] == '0);
    assert_qa_full_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(qa_o[o]) |-> cnt_i[0] == (ratio_i[0] >> 1));
    assert_qb_rise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(qb_o[o]) |-> cnt_i[1] == '0);
    assert_qb_full_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(qb_o[o]) |-> cnt_i[1] == (ratio_i[1] >> 1));
  end

  for (genvar o = 0; o < BANK_OUTS; o++) begin : g_c
    if (o >= BANK_OUTS / 2) begin : g_inv
      assert_qc_inv_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(qc_o[o]) |-> (inv_c_i ? cnt_i[2] == (ratio_i[2] >> 1) : cnt_i[2] == '0));
    end else begin : g_plain
      assert_qc_rise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(qc_o[o]) |-> cnt_i[2] == '0);
    end
  end

  assert_fb_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fb_o) |-> cnt_i[3] == '0);
  assert_fb_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fb_o) |-> cnt_i[3] == (ratio_i[3] >> 1));
endmodule

bind clkdiv_banks clkdiv_banks_chk #(.W(clkdiv_pkg::RATIO_W), .BANK_OUTS(BANK_OUTS)) u_chk (
  .clk_i, .rst_ni, .inv_c_i, .qa_o, .qb_o, .qc_o, .fb_o,
  .cnt_i(cnt_w), .ratio_i(ratio_w)
);

// File: tb/clkdiv_banks_bench.sv
module clkdiv_banks_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic [1:0]  sel_a = 2'd0, sel_b = 2'd0, sel_c = 2'd0;
  logic [2:0]  fb_sel = 3'd0;
  logic        vco_full = 1'b1, inv_c = 1'b0;
  logic [11:0] en = '1;
  logic [3:0]  qa, qb, qc;
  logic        fb;
  wire  [12:0] outs = {fb, qc, qb, qa};

  int total = 0, bad = 0;
  int mon_old = 2, mon_new = 2;
  bit mon_on = 1'b0;

  always #10 clk = ~clk;

  clkdiv_banks u_clkdiv_banks (
    .clk_i(clk), .rst_ni(rst_ni), .sel_a_i(sel_a), .sel_b_i(sel_b), .sel_c_i(sel_c),
    .fb_sel_i(fb_sel), .vco_full_i(vco_full), .inv_c_i(inv_c), .out_en_i(en),
    .qa_o(qa), .qb_o(qb), .qc_o(qc), .fb_o(fb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // bank 0..2 = A..C, 3 = feedback
  function automatic int period_of(input int bank, input int sel, input bit full);
    int r;
    case (bank)
      0:       r = (sel == 3) ? 12 : 4 + 2 * sel;
      1:       r = 4 + 2 * sel;
      2:       r = 2 + 2 * sel;
      default: r = (4 + 2 * (sel % 4)) * ((sel >= 4) ? 2 : 1);
    endcase
    return full ? r : 2 * r;
  endfunction

  task automatic measure(input int idx, input int exp_half, input string req, input string what);
    int hi = 0, lo = 0, guard = 0;
    @(negedge clk);
    while (outs[idx] !== 1'b0 && guard < 400) begin @(negedge clk); guard++; end
    while (outs[idx] !== 1'b1 && guard < 400) begin @(negedge clk); guard++; end
    while (outs[idx] === 1'b1 && guard < 400) begin hi++; @(negedge clk); guard++; end
    while (outs[idx] === 1'b0 && guard < 400) begin lo++; @(negedge clk); guard++; end
    check(hi == exp_half, req, hi, exp_half, {what, " high run"});
    check(lo == exp_half, req, lo, exp_half, {what, " low run"});
  endtask

  // run-length monitor on qa[0] (R6) and high pulses of qa[1] (R9)
  logic prev0 = 1'b0, prev1 = 1'b0;
  int run0 = 0, run1 = 0;
  bit seen0 = 1'b0, seen1 = 1'b0;
  always @(negedge clk) begin
    if (!rst_ni || !mon_on) begin
      seen0 = 1'b0; seen1 = 1'b0; run0 = 0; run1 = 0;
      prev0 = qa[0]; prev1 = qa[1];
    end else begin
      if (qa[0] != prev0) begin
        if (seen0) check(run0 == mon_old || run0 == mon_new, "R6", run0, mon_new, "qa0 run length");
        if (qa[0]) seen0 = 1'b1;
        run0 = 1;
      end else run0++;
      if (qa[1] != prev1) begin
        if (seen1 && prev1) check(run1 == mon_old || run1 == mon_new, "R9", run1, mon_new, "qa1 high pulse");
        if (qa[1]) seen1 = 1'b1;
        run1 = 1;
      end else run1++;
      prev0 = qa[0];
      prev1 = qa[1];
    end
  end

  task automatic settle();
    repeat (150) @(negedge clk);
    mon_old = mon_new;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit same;
    int hits;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check(outs == 13'd0, "R10", int'(outs), 0, "outputs during reset");
    rst_ni = 1'b1;
    // first period after release starts high (R10)
    @(negedge clk);
    check(fb == 1'b1, "R10", int'(fb), 1, "fb first half high");
    mon_new = period_of(0, 0, 1'b1) / 2;
    mon_old = mon_new;
    mon_on = 1'b1;
    settle();

    // on-the-fly sweep of bank selects and prescale
    for (int f = 1; f >= 0; f--) begin
      for (int s = 0; s < 4; s++) begin
        repeat (s + 3) @(negedge clk);
        mon_old = mon_new;
        mon_new = period_of(0, s, f[0]) / 2;
        sel_a = s[1:0]; sel_b = s[1:0]; sel_c = s[1:0]; vco_full = f[0];
        settle();
        measure(0, period_of(0, s, f[0]) / 2, f ? "R1" : "R5 R1", "qa0");
        measure(5, period_of(1, s, f[0]) / 2, f ? "R2" : "R5 R2", "qb1");
        measure(11, period_of(2, s, f[0]) / 2, f ? "R3" : "R5 R3", "qc3");
        same = 1'b1;
        for (int i = 0; i < 40; i++) begin
          @(negedge clk);
          if (qa != {4{qa[0]}} || qb != {4{qb[0]}} || qc != {4{qc[0]}}) same = 1'b0;
        end
        check(same, "R11", int'(same), 1, "bank outputs aligned");
      end
    end

    // feedback ratios
    for (int f = 1; f >= 0; f--) begin
      for (int s = 0; s < 8; s++) begin
        mon_old = mon_new;
        mon_new = period_of(0, 3, f[0]) / 2;
        fb_sel = s[2:0]; vco_full = f[0];
        settle();
        measure(12, period_of(3, s, f[0]) / 2, f ? "R4" : "R5 R4", "fb");
      end
    end

    // freeze and unfreeze
    mon_old = mon_new;
    mon_new = period_of(0, 1, 1'b1) / 2;
    sel_a = 2'd1; sel_b = 2'd1; sel_c = 2'd1; vco_full = 1'b1;
    settle();
    en[1] = 1'b0; en[6] = 1'b0; en[11] = 1'b0;
    repeat (60) @(negedge clk);
    hits = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (qa[1] || qb[2] || qc[3]) hits++;
    end
    check(hits == 0, "R8", hits, 0, "frozen outputs high samples");
    measure(0, 3, "R8", "qa0 still running");
    measure(9, period_of(2, 1, 1'b1) / 2, "R8", "qc1 still running");
    en = '1;
    repeat (60) @(negedge clk);
    measure(1, 3, "R9", "qa1 after unfreeze");
    for (int i = 0; i < 24; i++) begin
      en[1] = ~en[1];
      repeat (5 + i) @(negedge clk);
    end
    en = '1;
    repeat (60) @(negedge clk);

    // reset mid-run, then inverted upper bank C outputs
    mon_on = 1'b0;
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check(outs == 13'd0, "R10", int'(outs), 0, "outputs after mid-run reset");
    inv_c = 1'b1;
    @(negedge clk);
    rst_ni = 1'b1;
    mon_on = 1'b1;
    repeat (60) @(negedge clk);
    same = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (qc[2] != !qc[0] || qc[3] != !qc[0] || qc[1] != qc[0]) same = 1'b0;
    end
    check(same, "R7", int'(same), 1, "inverted qc2/qc3");
    en[10] = 1'b0;
    repeat (60) @(negedge clk);
    hits = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (qc[2]) hits++;
    end
    check(hits == 0, "R7 R8", hits, 0, "frozen inverted qc2 high samples");
    check(qc[3] == !qc[0], "R7", int'(qc[3]), int'(!qc[0]), "qc3 still inverted");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule